// File: doc/BRIEF.md
# Store-to-Load Forwarding Lookup

This block is a small circular store buffer that answers forwarding lookups from a two-stage load pipeline. Stores take a slot at the tail. Their address (virtual tag, physical tag and byte enables) and their data then arrive on two independent update ports. Each update sets its own valid flag. Entries retire from the head, and a flush input empties the whole buffer in one cycle.

A load presents its virtual and physical address, its byte mask, a precomputed slot mask naming the stores that are older than it, and its own ring position. In the same cycle the block returns a fast byte-match mask and a fast indication that some matched byte is still waiting for data. One cycle later it returns the forwarded bytes, the final mask of usable bytes, and three hazard flags: data not ready (with the blocking slot), address not known (with the blocking slot), and disagreement between virtual and physical matching. For each byte, the youngest older store wins. Age is judged by walking backwards around the ring from the load's position.

Top module: `fwd_lookup`

## Requirements
- R1: After reset the buffer is empty. A lookup returns a zero fast mask, a zero final mask, all three hazard flags low, and `alloc_slot` is 0.
- R2: Each `alloc_valid` cycle claims the slot shown on `alloc_slot`, which then advances by one modulo N (N is a power of two). A freshly claimed slot has both its address and its data marked not ready.
- R3: A store matches a load only when the store's slot is in use, it is marked older in `q_older`, its address is ready, its physical address agrees with the load's in bits [PA_W-1:4], and the two byte masks share at least one set bit. Forwarding uses the physical match.
- R4: For each requested byte, the supplying store is the first matching store found when stepping from slot `q_pos-1` downwards modulo N, wrapping past slot 0 to slot N-1.
- R5: In the cycle of the lookup, `fast_mask` bit b is 1 exactly when byte b is requested and some matching store writes it. `fast_data_inv` is 1 when any such supplying store has no data yet.
- R6: One cycle after a lookup, `out_valid` is 1. `fwd_mask` bit b is 1 when byte b has a supplier whose data is ready, and `fwd_data` byte b holds that supplier's byte (bit range 8b+7:8b); bytes without a ready supplier read 0.
- R7: `data_inv` is raised in the second stage when some requested byte's supplier lacks data. `data_inv_slot` then names the youngest such supplier.
- R8: `addr_inv` is raised in the second stage when an older in-use store has no address yet. `addr_inv_slot` names the youngest such store in ring order.
- R9: `match_inv` is raised in the second stage when, for some older store with a ready address, the virtual match (bits [VA_W-1:4] plus mask overlap) and the physical match disagree.
- R10: `free_valid` releases the slot at the head. A released slot no longer supplies bytes, even if the load still marks it older.
- R11: `flush` clears every slot's in-use flag and returns the head and tail to slot 0 in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empty the buffer in one cycle |
| alloc_valid | input | 1 | Claim the tail slot for a new store |
| alloc_slot | output | $clog2(N) | Slot that the next claim receives |
| free_valid | input | 1 | Release the head slot |
| st_addr_valid | input | 1 | Address update strobe |
| st_addr_slot | input | $clog2(N) | Slot receiving the address |
| st_va | input | VA_W | Store virtual address |
| st_pa | input | PA_W | Store physical address |
| st_mask | input | 16 | Store byte enables |
| st_data_valid | input | 1 | Data update strobe |
| st_data_slot | input | $clog2(N) | Slot receiving the data |
| st_data | input | 128 | Store data, byte b at bits 8b+7:8b |
| q_valid | input | 1 | Lookup request |
| q_va | input | VA_W | Load virtual address |
| q_pa | input | PA_W | Load physical address |
| q_mask | input | 16 | Bytes the load needs |
| q_older | input | N | Slots older than the load |
| q_pos | input | $clog2(N) | Load's position in the ring |
| fast_mask | output | 16 | First-stage matched bytes |
| fast_data_inv | output | 1 | First-stage data-not-ready hint |
| out_valid | output | 1 | Second-stage result valid |
| fwd_mask | output | 16 | Bytes with ready forwarded data |
| fwd_data | output | 128 | Forwarded bytes |
| data_inv | output | 1 | Supplier data not ready |
| data_inv_slot | output | $clog2(N) | Youngest supplier lacking data |
| addr_inv | output | 1 | Older store address unknown |
| addr_inv_slot | output | $clog2(N) | Youngest older store lacking address |
| match_inv | output | 1 | Virtual and physical matches disagree |

## Verification
The bench builds the block with its defaults: N = 8 slots, a 39-bit virtual address and a 36-bit physical address. Eight slots are few enough to fill the ring completely and wrap the tail. That places older stores on both sides of slot 0, so the backwards age walk across the wrap point is covered. Three overlapping stores with partial masks in one 16-byte lane give three different suppliers within one lookup. Address lanes that agree in one space and differ in the other trigger the match disagreement flag.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
    localparam int LANE_B = 16;
    localparam int LANE_W = LANE_B * 8;
    localparam int OFS_W  = 4;

    typedef struct packed {
        logic [LANE_B-1:0] mask;
        logic [LANE_W-1:0] data;
        logic              dinv;
        logic              ainv;
        logic              minv;
    } fwd_resp_t;

    // distance walked backwards from pos to reach slot, in 1..n (n when equal)
    function automatic int ring_dist(input int pos, input int slot, input int n);
        int d;
        d = (pos - slot + n) % n;
        return (d == 0) ? n : d;
    endfunction
endpackage

// File: rtl/fwd_slot_store.sv
module fwd_slot_store
    import fwd_pkg::*;
#(
    parameter int N    = 8,
    parameter int VA_W = 39,
    parameter int PA_W = 36,
    localparam int SW  = $clog2(N)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush,
    input  logic                 alloc_valid,
    output logic [SW-1:0]        tail,
    input  logic                 free_valid,
    input  logic                 au_valid,
    input  logic [SW-1:0]        au_slot,
    input  logic [VA_W-1:0]      au_va,
    input  logic [PA_W-1:0]      au_pa,
    input  logic [LANE_B-1:0]    au_mask,
    input  logic                 du_valid,
    input  logic [SW-1:0]        du_slot,
    input  logic [LANE_W-1:0]    du_data,
    output logic [N-1:0]         used,
    output logic [N-1:0]         av,
    output logic [N-1:0]         dv,
    output logic [VA_W-OFS_W-1:0] va_tag [N],
    output logic [PA_W-OFS_W-1:0] pa_tag [N],
    output logic [LANE_B-1:0]    bmask  [N],
    output logic [LANE_W-1:0]    bdata  [N]
);
    logic [SW-1:0] head;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            head <= '0;
            tail <= '0;
        end else begin
            if (alloc_valid) tail <= tail + 1'b1;
            if (free_valid)  head <= head + 1'b1;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || flush) begin
                used[i] <= 1'b0;
                av[i]   <= 1'b0;
                dv[i]   <= 1'b0;
            end else begin
                if (free_valid && head == SW'(i)) used[i] <= 1'b0;
                if (alloc_valid && tail == SW'(i)) begin
                    used[i] <= 1'b1;
                    av[i]   <= 1'b0;
                    dv[i]   <= 1'b0;
                end else begin
                    if (au_valid && au_slot == SW'(i)) av[i] <= 1'b1;
                    if (du_valid && du_slot == SW'(i)) dv[i] <= 1'b1;
                end
            end
        end

        always_ff @(posedge clk) begin
            if (au_valid && au_slot == SW'(i)) begin
                va_tag[i] <= au_va[VA_W-1:OFS_W];
                pa_tag[i] <= au_pa[PA_W-1:OFS_W];
                bmask[i]  <= au_mask;
            end
            if (du_valid && du_slot == SW'(i)) bdata[i] <= du_data;
        end
    end
endmodule

// File: rtl/fwd_select.sv
module fwd_select
    import fwd_pkg::*;
#(
    parameter int N    = 8,
    parameter int VA_W = 39,
    parameter int PA_W = 36,
    localparam int SW  = $clog2(N)
) (
    input  logic [N-1:0]          used,
    input  logic [N-1:0]          av,
    input  logic [N-1:0]          dv,
    input  logic [VA_W-OFS_W-1:0] va_tag [N],
    input  logic [PA_W-OFS_W-1:0] pa_tag [N],
    input  logic [LANE_B-1:0]     bmask  [N],
    input  logic [LANE_W-1:0]     bdata  [N],
    input  logic [VA_W-1:0]       q_va,
    input  logic [PA_W-1:0]       q_pa,
    input  logic [LANE_B-1:0]     q_mask,
    input  logic [N-1:0]          q_older,
    input  logic [SW-1:0]         q_pos,
    output logic [LANE_B-1:0]     fast_mask,
    output fwd_resp_t             resp,
    output logic [SW-1:0]         dinv_slot,
    output logic [SW-1:0]         ainv_slot
);
    logic [N-1:0] cand, pm, vm;

    always_comb begin
        logic [SW-1:0] idx;
        logic [SW-1:0] win;
        logic          have;
        int            best;
        for (int i = 0; i < N; i++) begin
            cand[i] = used[i] && q_older[i];
            pm[i] = cand[i] && av[i] && (pa_tag[i] == q_pa[PA_W-1:OFS_W])
                    && |(bmask[i] & q_mask);
            vm[i] = cand[i] && av[i] && (va_tag[i] == q_va[VA_W-1:OFS_W])
                    && |(bmask[i] & q_mask);
        end
        resp      = '0;
        fast_mask = '0;
        dinv_slot = '0;
        ainv_slot = '0;
        resp.minv = |(pm ^ vm);
        // walk oldest-first so that the youngest hit is written last
        for (int k = N; k >= 1; k--) begin
            idx = q_pos - SW'(k);
            if (cand[idx] && !av[idx]) begin
                resp.ainv = 1'b1;
                ainv_slot = idx;
            end
        end
        best = N + 1;
        for (int b = 0; b < LANE_B; b++) begin
            have = 1'b0;
            win  = '0;
            for (int k = N; k >= 1; k--) begin
                idx = q_pos - SW'(k);
                if (pm[idx] && bmask[idx][b]) begin
                    have = 1'b1;
                    win  = idx;
                end
            end
            if (have && q_mask[b]) begin
                fast_mask[b] = 1'b1;
                if (dv[win]) begin
                    resp.mask[b]       = 1'b1;
                    resp.data[8*b +: 8] = bdata[win][8*b +: 8];
                end else begin
                    resp.dinv = 1'b1;
                    if (ring_dist(int'(q_pos), int'(win), N) < best) begin
                        best      = ring_dist(int'(q_pos), int'(win), N);
                        dinv_slot = win;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/fwd_lookup.sv
module fwd_lookup
    import fwd_pkg::*;
#(
    parameter int N    = 8,
    parameter int VA_W = 39,
    parameter int PA_W = 36,
    localparam int SW  = $clog2(N)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush,
    input  logic                 alloc_valid,
    output logic [SW-1:0]        alloc_slot,
    input  logic                 free_valid,
    input  logic                 st_addr_valid,
    input  logic [SW-1:0]        st_addr_slot,
    input  logic [VA_W-1:0]      st_va,
    input  logic [PA_W-1:0]      st_pa,
    input  logic [LANE_B-1:0]    st_mask,
    input  logic                 st_data_valid,
    input  logic [SW-1:0]        st_data_slot,
    input  logic [LANE_W-1:0]    st_data,
    input  logic                 q_valid,
    input  logic [VA_W-1:0]      q_va,
    input  logic [PA_W-1:0]      q_pa,
    input  logic [LANE_B-1:0]    q_mask,
    input  logic [N-1:0]         q_older,
    input  logic [SW-1:0]        q_pos,
    output logic [LANE_B-1:0]    fast_mask,
    output logic                 fast_data_inv,
    output logic                 out_valid,
    output logic [LANE_B-1:0]    fwd_mask,
    output logic [LANE_W-1:0]    fwd_data,
    output logic                 data_inv,
    output logic [SW-1:0]        data_inv_slot,
    output logic                 addr_inv,
    output logic [SW-1:0]        addr_inv_slot,
    output logic                 match_inv
);
    logic [N-1:0]          used, av, dv;
    logic [VA_W-OFS_W-1:0] va_tag [N];
    logic [PA_W-OFS_W-1:0] pa_tag [N];
    logic [LANE_B-1:0]     bmask  [N];
    logic [LANE_W-1:0]     bdata  [N];
    fwd_resp_t             s1_resp, s2_resp;
    logic [SW-1:0]         s1_dslot, s1_aslot;

    fwd_slot_store #(.N(N), .VA_W(VA_W), .PA_W(PA_W)) u_store (
        .clk(clk), .rst(rst), .flush(flush),
        .alloc_valid(alloc_valid), .tail(alloc_slot), .free_valid(free_valid),
        .au_valid(st_addr_valid), .au_slot(st_addr_slot), .au_va(st_va),
        .au_pa(st_pa), .au_mask(st_mask),
        .du_valid(st_data_valid), .du_slot(st_data_slot), .du_data(st_data),
        .used(used), .av(av), .dv(dv),
        .va_tag(va_tag), .pa_tag(pa_tag), .bmask(bmask), .bdata(bdata)
    );

    fwd_select #(.N(N), .VA_W(VA_W), .PA_W(PA_W)) u_select (
        .used(used), .av(av), .dv(dv),
        .va_tag(va_tag), .pa_tag(pa_tag), .bmask(bmask), .bdata(bdata),
        .q_va(q_va), .q_pa(q_pa), .q_mask(q_mask),
        .q_older(q_older), .q_pos(q_pos),
        .fast_mask(fast_mask), .resp(s1_resp),
        .dinv_slot(s1_dslot), .ainv_slot(s1_aslot)
    );

    assign fast_data_inv = s1_resp.dinv;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid     <= 1'b0;
            s2_resp       <= '0;
            data_inv_slot <= '0;
            addr_inv_slot <= '0;
        end else begin
            out_valid     <= q_valid;
            s2_resp       <= q_valid ? s1_resp : '0;
            data_inv_slot <= q_valid ? s1_dslot : '0;
            addr_inv_slot <= q_valid ? s1_aslot : '0;
        end
    end

    assign fwd_mask  = s2_resp.mask;
    assign fwd_data  = s2_resp.data;
    assign data_inv  = s2_resp.dinv;
    assign addr_inv  = s2_resp.ainv;
    assign match_inv = s2_resp.minv;
endmodule

// File: rtl/fwd_lookup_chk.sv
module fwd_lookup_chk #(
    parameter int N   = 8,
    localparam int SW = $clog2(N)
) (
    input logic          clk,
    input logic          rst,
    input logic          flush,
    input logic          alloc_valid,
    input logic [SW-1:0] alloc_slot,
    input logic          q_valid,
    input logic [15:0]   q_mask,
    input logic [15:0]   fast_mask,
    input logic          fast_data_inv,
    input logic          out_valid,
    input logic [15:0]   fwd_mask,
    input logic          data_inv
);
    // R2
    tail_step_chk: assert property (@(posedge clk) disable iff (rst)
        (alloc_valid && !flush) |=> alloc_slot == SW'($past(alloc_slot) + 1'b1));
    // R11
    flush_home_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> alloc_slot == '0);
    // R5
    fast_within_req_chk: assert property (@(posedge clk) disable iff (rst)
        q_valid |-> (fast_mask & ~q_mask) == '0);
    // R6
    stage_delay_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> out_valid == $past(q_valid));
    // R6
    final_within_fast_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (fwd_mask & ~$past(fast_mask)) == '0);
    // R7
    dinv_follows_hint_chk: assert property (@(posedge clk) disable iff (rst)
        data_inv |-> $past(fast_data_inv));
endmodule

bind fwd_lookup fwd_lookup_chk #(.N(N)) u_fwd_lookup_chk (
    .clk(clk), .rst(rst), .flush(flush),
    .alloc_valid(alloc_valid), .alloc_slot(alloc_slot),
    .q_valid(q_valid), .q_mask(q_mask),
    .fast_mask(fast_mask), .fast_data_inv(fast_data_inv),
    .out_valid(out_valid), .fwd_mask(fwd_mask), .data_inv(data_inv)
);

// File: tb/test_fwd_lookup.sv
module test_fwd_lookup;
    localparam int N = 8, VA_W = 39, PA_W = 36, SW = 3;

    logic clk = 0, rst = 1, flush = 0, alloc_valid = 0, free_valid = 0;
    logic [SW-1:0] alloc_slot;
    logic st_addr_valid = 0, st_data_valid = 0;
    logic [SW-1:0] st_addr_slot = 0, st_data_slot = 0;
    logic [VA_W-1:0] st_va = 0, q_va = 0;
    logic [PA_W-1:0] st_pa = 0, q_pa = 0;
    logic [15:0] st_mask = 0, q_mask = 0;
    logic [127:0] st_data = 0;
    logic q_valid = 0;
    logic [N-1:0] q_older = 0;
    logic [SW-1:0] q_pos = 0;
    logic [15:0] fast_mask, fwd_mask;
    logic fast_data_inv, out_valid, data_inv, addr_inv, match_inv;
    logic [127:0] fwd_data;
    logic [SW-1:0] data_inv_slot, addr_inv_slot;

    int n_chk = 0, n_bad = 0;
    logic [15:0] f_mask; logic f_dinv;

    localparam logic [PA_W-1:0] PA_A = 36'h0_1234_5670, PA_B = 36'h0_1234_5680;
    localparam logic [VA_W-1:0] VA_A = 39'h00_8000_1230, VA_B = 39'h00_8000_1240;

    always #10 clk = ~clk;

    fwd_lookup #(.N(N), .VA_W(VA_W), .PA_W(PA_W)) i_fwd_lookup (.*);

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: act=hung exp=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    function automatic logic [127:0] pat(input logic [7:0] base, input logic [15:0] m);
        logic [127:0] r = '0;
        for (int b = 0; b < 16; b++) if (m[b]) r[8*b +: 8] = base + 8'(b);
        return r;
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic alloc(input int n);
        for (int i = 0; i < n; i++) begin
            alloc_valid = 1; @(negedge clk); alloc_valid = 0;
        end
    endtask

    task automatic set_addr(input logic [SW-1:0] s, input logic [VA_W-1:0] va,
                            input logic [PA_W-1:0] pa, input logic [15:0] m);
        st_addr_valid = 1; st_addr_slot = s; st_va = va; st_pa = pa; st_mask = m;
        @(negedge clk); st_addr_valid = 0;
    endtask

    task automatic set_data(input logic [SW-1:0] s, input logic [127:0] d);
        st_data_valid = 1; st_data_slot = s; st_data = d;
        @(negedge clk); st_data_valid = 0;
    endtask

    // drive at a falling edge, read fast outputs, read stage two a cycle on
    task automatic lookup(input logic [SW-1:0] pos, input logic [N-1:0] older,
                          input logic [VA_W-1:0] va, input logic [PA_W-1:0] pa,
                          input logic [15:0] m);
        q_valid = 1; q_pos = pos; q_older = older; q_va = va; q_pa = pa; q_mask = m;
        #1; f_mask = fast_mask; f_dinv = fast_data_inv;
        @(negedge clk); q_valid = 0;
    endtask

    task automatic t_reset;
        lookup(0, 8'hFF, VA_A, PA_A, 16'hFFFF);
        chk("R1 fast_mask", 128'(f_mask), 0);
        chk("R1 fwd_mask", 128'(fwd_mask), 0);
        chk("R1 flags", {data_inv, addr_inv, match_inv}, 0);
        chk("R1 alloc_slot", 128'(alloc_slot), 0);
    endtask

    task automatic t_fresh;
        alloc(4);
        chk("R2 alloc_slot after 4", 128'(alloc_slot), 4);
        lookup(4, 8'h0F, VA_A, PA_A, 16'hFFFF);
        chk("R8 addr_inv", 128'(addr_inv), 1);
        chk("R8 addr_inv_slot", 128'(addr_inv_slot), 3);
        chk("R2 fresh no forward", 128'(f_mask), 0);
    endtask

    task automatic t_merge;
        set_addr(0, VA_A, PA_A, 16'hFFFF);
        set_addr(1, VA_A, PA_A, 16'h00F0);
        set_addr(2, VA_A, PA_A, 16'h000F);
        set_addr(3, VA_B, PA_B, 16'hFFFF);
        set_data(0, pat(8'h10, 16'hFFFF));
        set_data(1, pat(8'h20, 16'hFFFF));
        set_data(3, pat(8'h90, 16'hFFFF));
        lookup(4, 8'h0F, VA_A, PA_A, 16'hFFFF);
        chk("R5 fast_mask", 128'(f_mask), 16'hFFFF);
        chk("R5 fast_data_inv", 128'(f_dinv), 1);
        chk("R6 out_valid", 128'(out_valid), 1);
        chk("R6 fwd_mask partial", 128'(fwd_mask), 16'hFFF0);
        chk("R4 fwd_data youngest", fwd_data, pat(8'h20, 16'h00F0) | pat(8'h10, 16'hFF00));
        chk("R7 data_inv", 128'(data_inv), 1);
        chk("R7 data_inv_slot", 128'(data_inv_slot), 2);
        chk("R9 no mismatch", 128'(match_inv), 0);
        chk("R8 addr known", 128'(addr_inv), 0);
        set_data(2, pat(8'h30, 16'hFFFF));
        lookup(4, 8'h0F, VA_A, PA_A, 16'hFFFF);
        chk("R6 fwd_mask full", 128'(fwd_mask), 16'hFFFF);
        chk("R6 fwd_data full", fwd_data,
            pat(8'h30, 16'h000F) | pat(8'h20, 16'h00F0) | pat(8'h10, 16'hFF00));
        chk("R7 cleared", 128'(data_inv), 0);
        lookup(1, 8'h01, VA_A, PA_A, 16'h0FF0);
        chk("R3 only older slot", fwd_data, pat(8'h10, 16'h0FF0));
        chk("R6 mask limited to request", 128'(fwd_mask), 16'h0FF0);
        lookup(4, 8'h0F, VA_B, PA_B, 16'h0003);
        chk("R3 other lane", fwd_data, pat(8'h90, 16'h0003));
        lookup(4, 8'h0F, VA_A + 39'h100, PA_A + 36'h100, 16'hFFFF);
        chk("R3 no lane hit", 128'(fwd_mask), 0);
        lookup(4, 8'h0F, VA_A + 39'h40, PA_A, 16'hFFFF);
        chk("R9 match_inv", 128'(match_inv), 1);
    endtask

    task automatic t_free;
        free_valid = 1; @(negedge clk); free_valid = 0;
        lookup(4, 8'h0F, VA_A, PA_A, 16'hFFFF);
        chk("R10 freed slot skipped", 128'(fwd_mask), 16'h00FF);
        chk("R10 data", fwd_data, pat(8'h30, 16'h000F) | pat(8'h20, 16'h00F0));
    endtask

    task automatic t_flush;
        flush = 1; @(negedge clk); flush = 0;
        chk("R11 alloc_slot home", 128'(alloc_slot), 0);
        lookup(4, 8'hFF, VA_A, PA_A, 16'hFFFF);
        chk("R11 empty fast", 128'(f_mask), 0);
        chk("R11 empty flags", {data_inv, addr_inv, match_inv, fwd_mask}, 0);
    endtask

    task automatic t_wrap;
        alloc(8);
        chk("R2 wraps to 0", 128'(alloc_slot), 0);
        set_addr(6, VA_A, PA_A, 16'hFFFF); set_data(6, pat(8'h60, 16'hFFFF));
        set_addr(7, VA_A, PA_A, 16'hFFFF); set_data(7, pat(8'h70, 16'hFFFF));
        set_addr(0, VA_A, PA_A, 16'h00FF); set_data(0, pat(8'h80, 16'hFFFF));
        lookup(1, 8'hC1, VA_A, PA_A, 16'hFFFF);
        chk("R4 wrap youngest", fwd_data, pat(8'h80, 16'h00FF) | pat(8'h70, 16'hFF00));
        lookup(0, 8'hC0, VA_A, PA_A, 16'hFFFF);
        chk("R4 before wrap", fwd_data, pat(8'h70, 16'hFFFF));
        lookup(6, 8'h3F, VA_A, PA_A, 16'hFFFF);
        chk("R8 youngest unknown", 128'(addr_inv_slot), 5);
        chk("R8 flag", 128'(addr_inv), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset; t_fresh; t_merge; t_free; t_flush; t_wrap;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule